// File: doc/BRIEF.md
# Parallel LCD Bus Read Prefetcher

This block is the host-side master for read traffic on an 8-bit, 6800-style parallel LCD bus. A processor read of the main data register starts one bus read. The value returned by that same read is the byte captured by the transfer before it. A run of N bytes therefore takes one dummy read, then N-1 reads of the main register, and then one read of the alias register. The alias register returns the held byte without starting another bus cycle.

Each bus cycle raises the enable strobe for a programmable number of wait clocks. The data lines are captured on the clock where that count expires. The rest of a programmable cycle length is recovery time. A main read that arrives while a cycle is still running is queued. At most one read can be queued. The queued transfer starts as soon as the running cycle ends, and the transfer-in-progress flag stays high across both transfers. A one-clock interrupt pulse marks each captured byte.

Top module: `lcd_rd_prefetch`

## Requirements
- R1: After a synchronous active-high reset, `tip_o`, `busy_o` and `irq_o` are 0, the held byte is 0 (an alias read returns 0), and `lcd_e_o` sits at its inactive level.
- R2: In the cycle where `rd_data_i` is high, `busy_o` is 1 and `rdata_o` shows the byte held before this read. `tip_o` is high from the next cycle on.
- R3: A started transfer drives the enable strobe active for exactly W clocks, beginning in the cycle after the starting read. `lcd_rw_o` is always 1.
- R4: When `cfg_e_low_i` = 0 the strobe is active high. When it is 1 the strobe is active low. The strobe holds its inactive level whenever `tip_o` is 0.
- R5: `lcd_d_i` is captured at the clock edge that ends the last active strobe clock. In the following cycle, `irq_o` is high for that one cycle, the captured byte is readable, and `busy_o` is 0 unless another read is queued.
- R6: A transfer occupies C clocks counted from its first strobe clock. `tip_o` falls after them if no read is queued.
- R7: A main read arriving while a transfer runs is queued. The next transfer starts in the clock right after the running one ends, and `tip_o` stays high in between.
- R8: Main reads arriving while a read is already queued are ignored. No third transfer occurs.
- R9: An alias read (`rd_alias_i`) returns the held byte and starts no transfer. `tip_o` stays 0 and the strobe stays idle.
- R10: `rdata_o` is 0 in any cycle with neither read strobe. When both strobes are high together, the cycle is treated as a main read.
- R11: A wait count of 0 acts as 1. A cycle count below the effective wait count acts as that wait count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_data_i | input | 1 | Processor read strobe of the main data register |
| rd_alias_i | input | 1 | Processor read strobe of the alias data register |
| cfg_e_low_i | input | 1 | Strobe polarity: 0 active high, 1 active low |
| cfg_wait_i | input | CNT_W | Wait count W (strobe clocks) |
| cfg_cycle_i | input | CNT_W | Cycle count C (total clocks per transfer) |
| rdata_o | output | DATA_W | Read data returned for either strobe |
| busy_o | output | 1 | A requested byte is not yet captured |
| tip_o | output | 1 | Bus transfer in progress |
| irq_o | output | 1 | One-cycle pulse after each capture |
| lcd_rw_o | output | 1 | Bus direction, held at 1 (read) |
| lcd_e_o | output | 1 | Bus enable strobe |
| lcd_d_i | input | DATA_W | Bus data lines |

## Verification
A wrong wait or cycle counter shows at the strobe pin within the first transfer. The strobe length, the position of the interrupt pulse and the fall of `tip_o` each move by the counting error. A lost or doubled queue entry shows one transfer later: a missing or extra strobe burst, a missing or extra interrupt pulse, or a wrong alias value. Sweeping every small wait and cycle setting, both polarities and every arrival slot of a queued read exposes each of these within a few tens of clocks of the fault.

// File: rtl/lcd_rdp_pkg.sv
package lcd_rdp_pkg;

    // Strobe polarity selection
    typedef enum logic {
        E_ACT_HIGH = 1'b0,
        E_ACT_LOW  = 1'b1
    } e_pol_t;

    // Level driven on the strobe pin for a given activity and polarity
    function automatic logic e_level(input logic active, input e_pol_t pol);
        return (pol == E_ACT_LOW) ? ~active : active;
    endfunction

endpackage

// File: rtl/lcd_rdp_timer.sv
module lcd_rdp_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go_i,
    input  logic [CNT_W-1:0] wait_i,
    input  logic [CNT_W-1:0] cycle_i,
    output logic             run_o,
    output logic             e_on_o,
    output logic             smp_o,
    output logic             fin_o
);
    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t s_q, s_d;

    always_comb begin
        run_o  = s_q.run;
        e_on_o = s_q.run && (s_q.cnt < wait_i);
        smp_o  = s_q.run && (s_q.cnt == wait_i - CNT_W'(1));
        fin_o  = s_q.run && (s_q.cnt == cycle_i - CNT_W'(1));

        s_d = s_q;
        if (go_i) begin
            s_d.run = 1'b1;
            s_d.cnt = '0;
        end else if (fin_o) begin
            s_d.run = 1'b0;
            s_d.cnt = '0;
        end else if (s_q.run) begin
            s_d.cnt = s_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end
endmodule

// File: rtl/lcd_rdp_req.sv
module lcd_rdp_req (
    input  logic clk,
    input  logic rst,
    input  logic rd_i,
    input  logic run_i,
    input  logic smp_i,
    input  logic fin_i,
    output logic go_o,
    output logic busy_o,
    output logic tip_o
);
    typedef struct packed {
        logic busy;
        logic pend;
        logic tip;
    } req_t;

    req_t s_q, s_d;

    always_comb begin
        // Start a transfer from idle, or chain one when the running one ends
        go_o   = (rd_i && !run_i) || (fin_i && (s_q.pend || rd_i));
        busy_o = s_q.busy || rd_i;

        s_d = s_q;
        if (fin_i)
            s_d.pend = 1'b0;
        else if (run_i && rd_i)
            s_d.pend = 1'b1;

        if (rd_i)
            s_d.busy = 1'b1;
        else if (smp_i)
            s_d.busy = s_q.pend;

        s_d.tip = go_o || (run_i && !fin_i);
        tip_o   = s_q.tip;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end
endmodule

// File: rtl/lcd_rdp_capture.sv
module lcd_rdp_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_i,
    input  logic [DATA_W-1:0] bus_i,
    output logic [DATA_W-1:0] data_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              irq;
    } cap_t;

    cap_t s_q, s_d;

    always_comb begin
        s_d     = s_q;
        s_d.irq = smp_i;
        if (smp_i) s_d.data = bus_i;
        data_o  = s_q.data;
        irq_o   = s_q.irq;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end
endmodule

// File: rtl/lcd_rd_prefetch.sv
module lcd_rd_prefetch
    import lcd_rdp_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_data_i,
    input  logic              rd_alias_i,
    input  logic              cfg_e_low_i,
    input  logic [CNT_W-1:0]  cfg_wait_i,
    input  logic [CNT_W-1:0]  cfg_cycle_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              busy_o,
    output logic              tip_o,
    output logic              irq_o,
    output logic              lcd_rw_o,
    output logic              lcd_e_o,
    input  logic [DATA_W-1:0] lcd_d_i
);
    localparam logic [CNT_W-1:0] MIN_WAIT = CNT_W'(1);

    logic [CNT_W-1:0]  wait_eff, cycle_eff;
    logic              go, run, e_on, smp, fin;
    logic [DATA_W-1:0] held;

    // Clamp the timing settings to a usable range
    always_comb begin
        wait_eff  = (cfg_wait_i == '0) ? MIN_WAIT : cfg_wait_i;
        cycle_eff = (cfg_cycle_i < wait_eff) ? wait_eff : cfg_cycle_i;
    end

    lcd_rdp_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .go_i    (go),
        .wait_i  (wait_eff),
        .cycle_i (cycle_eff),
        .run_o   (run),
        .e_on_o  (e_on),
        .smp_o   (smp),
        .fin_o   (fin)
    );

    lcd_rdp_req u_req (
        .clk    (clk),
        .rst    (rst),
        .rd_i   (rd_data_i),
        .run_i  (run),
        .smp_i  (smp),
        .fin_i  (fin),
        .go_o   (go),
        .busy_o (busy_o),
        .tip_o  (tip_o)
    );

    lcd_rdp_capture #(.DATA_W(DATA_W)) u_cap (
        .clk    (clk),
        .rst    (rst),
        .smp_i  (smp),
        .bus_i  (lcd_d_i),
        .data_o (held),
        .irq_o  (irq_o)
    );

    always_comb begin
        rdata_o  = (rd_data_i || rd_alias_i) ? held : '0;
        lcd_rw_o = 1'b1;
        lcd_e_o  = e_level(e_on, e_pol_t'(cfg_e_low_i));
    end
endmodule

// File: rtl/lcd_rdp_chk.sv
module lcd_rdp_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_data_i,
    input logic              rd_alias_i,
    input logic              cfg_e_low_i,
    input logic              tip_o,
    input logic              busy_o,
    input logic              irq_o,
    input logic              lcd_e_o,
    input logic [DATA_W-1:0] rdata_o
);
    logic past_ok;

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    // R2
    tip_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        rd_data_i |=> tip_o);

    // R4
    e_idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        !tip_o |-> (lcd_e_o == cfg_e_low_i));

    // R5
    irq_follows_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> $past(lcd_e_o != cfg_e_low_i));

    // R6
    idle_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (!tip_o && !rd_data_i) |-> !busy_o);

    // R9
    alias_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && rd_alias_i && !rd_data_i && !irq_o
         && $past(rd_alias_i && !rd_data_i)) |-> (rdata_o == $past(rdata_o)));
endmodule

bind lcd_rd_prefetch lcd_rdp_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rd_data_i   (rd_data_i),
    .rd_alias_i  (rd_alias_i),
    .cfg_e_low_i (cfg_e_low_i),
    .tip_o       (tip_o),
    .busy_o      (busy_o),
    .irq_o       (irq_o),
    .lcd_e_o     (lcd_e_o),
    .rdata_o     (rdata_o)
);

// File: tb/lcd_rd_prefetch_test.sv
module lcd_rd_prefetch_test;
    localparam int PERIOD = 10;
    localparam int DW = 8;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rd_data = 1'b0, rd_alias = 1'b0, pol = 1'b0;
    logic [CW-1:0] wcfg = 4'd2, ccfg = 4'd3;
    logic [DW-1:0] rdata, lcd_d = '0;
    logic          busy, tip, irq, rw, e;

    int total = 0, fails = 0;
    int prev = 0;
    bit done = 0;

    lcd_rd_prefetch #(.DATA_W(DW), .CNT_W(CW)) uut (
        .clk(clk), .rst(rst), .rd_data_i(rd_data), .rd_alias_i(rd_alias),
        .cfg_e_low_i(pol), .cfg_wait_i(wcfg), .cfg_cycle_i(ccfg),
        .rdata_o(rdata), .busy_o(busy), .tip_o(tip), .irq_o(irq),
        .lcd_rw_o(rw), .lcd_e_o(e), .lcd_d_i(lcd_d));

    always #(PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (W=%0d C=%0d pol=%0d)",
                     req, act, exp, wcfg, ccfg, pol);
        end
    endtask

    function automatic int weff(input int w);
        return (w == 0) ? 1 : w;
    endfunction

    function automatic int ceff(input int w, input int c);
        return (c < weff(w)) ? weff(w) : c;
    endfunction

    // Per-cycle port checks of a transfer window
    task automatic cyc_chk(input int j, input bit e_act, input bit tip_x,
                           input bit irq_x, input bit busy_x);
        chk(e == (e_act ^ pol), "R3/R4 strobe", e, e_act ^ pol);
        chk(tip == tip_x, "R6/R7 tip", tip, tip_x);
        chk(irq == irq_x, "R5 irq", irq, irq_x);
        chk(busy == busy_x, "R5/R7 busy", busy, busy_x);
        chk(rw == 1'b1, "R3 rw", rw, 1);
        if (j < 0) $display("unused");
    endtask

    task automatic alias_read(input int exp);
        @(negedge clk);
        rd_alias = 1'b1;
        #1;
        chk(rdata == exp[DW-1:0], "R9 alias data", rdata, exp);
        @(negedge clk);
        rd_alias = 1'b0;
        for (int k = 0; k < 3; k++) begin
            #1;
            chk(tip == 1'b0, "R9 no transfer tip", tip, 0);
            chk(e == pol, "R9 strobe idle", e, pol);
            @(negedge clk);
        end
    endtask

    task automatic single(input int w, input int c);
        int we, ce, n, d;
        we = weff(w);
        ce = ceff(w, c);
        n  = ((ce > we) ? ce : we + 1) + 1;
        d  = (w * 37 + c * 11 + pol * 101 + 5) & 8'hFF;
        lcd_d = d[DW-1:0];
        @(negedge clk);
        rd_data = 1'b1;
        #1;
        chk(busy == 1'b1, "R2 busy same cycle", busy, 1);
        chk(rdata == prev[DW-1:0], "R2 returns previous byte", rdata, prev);
        chk(tip == 1'b0, "R2 tip not yet", tip, 0);
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            rd_data = 1'b0;
            #1;
            if (j == 0) chk(rdata == '0, "R10 no strobe zero", rdata, 0);
            cyc_chk(j, j < we, j < ce, j == we, j < we);
        end
        lcd_d = ~lcd_d;
        alias_read(d);
        prev = d;
    endtask

    task automatic queued(input int w, input int c, input int q);
        int we, ce, d1, d2;
        bit extra;
        we = weff(w);
        ce = ceff(w, c);
        extra = (q + 1 < ce);
        d1 = (w * 13 + c * 7 + q * 29 + 3) & 8'hFF;
        d2 = (d1 ^ 8'h5A) & 8'hFF;
        lcd_d = d1[DW-1:0];
        @(negedge clk);
        rd_data = 1'b1;
        #1;
        chk(rdata == prev[DW-1:0], "R2 returns previous byte", rdata, prev);
        for (int j = 0; j < 2 * ce + 2; j++) begin
            @(negedge clk);
            rd_data = (j == q) || (extra && j == q + 1);
            if (j == we) lcd_d = d2[DW-1:0];
            #1;
            if (rd_data)
                chk(rdata == ((j >= we) ? d1[DW-1:0] : prev[DW-1:0]),
                    "R7 queued read data", rdata, (j >= we) ? d1 : prev);
            cyc_chk(j, (j < we) || (j >= ce && j < ce + we), j < 2 * ce,
                    (j == we) || (j == ce + we),
                    (j < we) || (j >= q && j < ce + we));
        end
        rd_data = 1'b0;
        // R8: after the second transfer only idle cycles remain
        alias_read(d2);
        prev = d2;
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1
        chk(tip == 1'b0, "R1 tip reset", tip, 0);
        chk(busy == 1'b0, "R1 busy reset", busy, 0);
        chk(irq == 1'b0, "R1 irq reset", irq, 0);
        chk(e == pol, "R1 strobe inactive", e, pol);
        alias_read(0);

        // R3 R4 R5 R6 R11 sweep including clamped settings
        for (int p = 0; p < 2; p++) begin
            for (int w = 0; w < 5; w++) begin
                for (int c = 0; c < 7; c++) begin
                    @(negedge clk);
                    pol = p[0];
                    wcfg = w[CW-1:0];
                    ccfg = c[CW-1:0];
                    single(w, c);
                end
            end
        end

        // R7 R8 queue sweep over arrival slots
        pol = 1'b0;
        for (int w = 1; w < 4; w++) begin
            for (int c = 0; c < 6; c++) begin
                for (int q = 0; q < ceff(w, c); q++) begin
                    @(negedge clk);
                    wcfg = w[CW-1:0];
                    ccfg = c[CW-1:0];
                    queued(w, c, q);
                end
            end
        end

        // R10: both strobes together act as a main read
        @(negedge clk);
        wcfg = 4'd2;
        ccfg = 4'd3;
        rd_data = 1'b1;
        rd_alias = 1'b1;
        @(negedge clk);
        rd_data = 1'b0;
        rd_alias = 1'b0;
        #1;
        chk(tip == 1'b1, "R10 both strobes start transfer", tip, 1);
        repeat (5) @(negedge clk);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule